// File: doc/BRIEF.md
# Algebraic Right Shift with Rotate-Out Word

This unit performs a 32-bit arithmetic right shift for a legacy instruction set. Alongside the shifted result it also produces a rotated copy of the source word, meant for a multiply-quotient side register, and a carry flag. The unit takes a source word and a shift operand. The low five bits of the shift operand give the rotation count. The next bit up, of weight 32, chooses the behaviour: when it is clear the unit shifts by the count, and when it is set the result is filled entirely with the source sign.

All three results are captured in registers on the clock edge where the valid strobe is high. A done pulse accompanies them one cycle later. Condition-register updates, register-file writeback and instruction decode are handled elsewhere.

Top module: `sra_mq_unit`

## Requirements
- R1: The rotation count is bits [4:0] of `shift_opnd`. Bits [31:6] of `shift_opnd` have no effect on any output.
- R2: `mq_word` equals `src_word` rotated right by the count. Bits leaving position 0 re-enter at position 31. A count of 0 gives `src_word` unchanged.
- R3: When `shift_opnd[5]` is 0, `dst_word` equals `src_word` shifted right arithmetically by the count. The top count bits are copies of `src_word[31]`.
- R4: When `shift_opnd[5]` is 1, every bit of `dst_word` equals `src_word[31]`, whatever the count.
- R5: The choice of behaviour depends only on `shift_opnd[5]`. For example, an operand of 64 (bit 5 clear) acts as a shift by 0, not as a full sign fill.
- R6: When `shift_opnd[5]` is 0, `out_carry` is 1 exactly when `src_word[31]` is 1 and at least one of the count low-order bits of `src_word` is 1.
- R7: `out_carry` is 0 whenever `src_word[31]` is 0, even if nonzero bits were shifted out.
- R8: When `shift_opnd[5]` is 1, `out_carry` is 0.
- R9: The results appear on the outputs one clock edge after `in_valid` is sampled high. In that same cycle `out_done` is high for exactly one cycle. When `in_valid` is low, the outputs keep their previous values.
- R10: While `rst` is high, `out_done`, `dst_word`, `mq_word` and `out_carry` are all 0 after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands valid; capture results on this edge |
| src_word | input | 32 | Source word to be shifted |
| shift_opnd | input | 32 | Shift operand: [4:0] count, [5] full-fill select |
| out_done | output | 1 | One-cycle pulse marking fresh results |
| dst_word | output | 32 | Shifted destination word |
| mq_word | output | 32 | Source rotated right by the count |
| out_carry | output | 1 | Carry: negative source and nonzero bits lost |

## Verification
Negative and positive sources are each run across counts of 0, 1, 31 and several mid values. These runs separate a true arithmetic shift from a logical one, and show that carry depends on the source sign. Sources whose shifted-out bits are all zero, and sources where a single lost bit is set, show that carry is the OR of exactly the discarded bits. Operands with bit 5 set, and operands with only higher bits set (64, 0xFFFFFFC3), show that the single select bit, and no magnitude compare, picks the sign-fill path. They also show that the count still drives the rotated output in that path. Idle cycles between requests check that the done pulse lasts one cycle and that the results hold.

// File: rtl/sra_mq_pkg.sv
package sra_mq_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned CNT_W   = $clog2(WORD_W);
    localparam int unsigned SEL_BIT = CNT_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef enum logic {
        MODE_PARTIAL = 1'b0,
        MODE_FULL    = 1'b1
    } fill_mode_e;

    typedef struct packed {
        word_t dst;
        word_t mq;
        logic  carry;
    } sra_result_t;

    // Only the select bit chooses the path; the operand is never compared.
    function automatic fill_mode_e decode_mode(input word_t opnd);
        return opnd[SEL_BIT] ? MODE_FULL : MODE_PARTIAL;
    endfunction

    function automatic cnt_t shift_count(input word_t opnd);
        return opnd[CNT_W-1:0];
    endfunction

endpackage

// File: rtl/sra_rotr.sv
module sra_rotr #(
    parameter  int W  = 32,
    localparam int CW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [CW-1:0] amt,
    output logic [W-1:0]  dout
);
    logic [W-1:0] stage [CW+1];

    assign stage[0] = din;

    for (genvar s = 0; s < CW; s++) begin : g_stage
        localparam int D = 1 << s;
        assign stage[s+1] = amt[s] ? {stage[s][D-1:0], stage[s][W-1:D]} : stage[s];
    end

    assign dout = stage[CW];
endmodule

// File: rtl/sra_mask_gen.sv
module sra_mask_gen #(
    parameter  int W  = 32,
    localparam int CW = $clog2(W)
) (
    input  logic [CW-1:0] amt,
    input  logic          full,
    output logic [W-1:0]  mask
);
    // count leading zeros then ones; full-fill forces all ones
    always_comb begin
        if (full) mask = '1;
        else      mask = {W{1'b1}} >> amt;
    end
endmodule

// File: rtl/sra_merge.sv
module sra_merge #(
    parameter int W = 32
) (
    input  logic [W-1:0] rot,
    input  logic [W-1:0] mask,
    input  logic         sign,
    input  logic         full,
    output logic [W-1:0] dst,
    output logic         carry
);
    logic [W-1:0] fill;
    logic [W-1:0] lost;

    assign fill = {W{sign}};
    assign lost = rot & ~mask;

    always_comb begin
        if (full) dst = fill;
        else      dst = (rot & mask) | (fill & ~mask);
    end

    assign carry = sign & (|lost);
endmodule

// File: rtl/sra_mq_unit.sv
module sra_mq_unit
    import sra_mq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] src_word,
    input  logic [31:0] shift_opnd,
    output logic        out_done,
    output logic [31:0] dst_word,
    output logic [31:0] mq_word,
    output logic        out_carry
);
    fill_mode_e  mode;
    cnt_t        cnt;
    word_t       rot;
    word_t       mask;
    sra_result_t nxt;
    sra_result_t res_q;
    logic        done_q;

    assign mode = decode_mode(shift_opnd);
    assign cnt  = shift_count(shift_opnd);

    sra_rotr #(.W(WORD_W)) u_rot (
        .din  (src_word),
        .amt  (cnt),
        .dout (rot)
    );

    sra_mask_gen #(.W(WORD_W)) u_mask (
        .amt  (cnt),
        .full (mode == MODE_FULL),
        .mask (mask)
    );

    sra_merge #(.W(WORD_W)) u_merge (
        .rot   (rot),
        .mask  (mask),
        .sign  (src_word[WORD_W-1]),
        .full  (mode == MODE_FULL),
        .dst   (nxt.dst),
        .carry (nxt.carry)
    );

    assign nxt.mq = rot;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= in_valid;
            if (in_valid) res_q <= nxt;
        end
    end

    assign out_done  = done_q;
    assign dst_word  = res_q.dst;
    assign mq_word   = res_q.mq;
    assign out_carry = res_q.carry;
endmodule

// File: rtl/sra_mq_checker.sv
module sra_mq_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] src_word,
    input logic [31:0] shift_opnd,
    input logic        out_done,
    input logic [31:0] dst_word,
    input logic [31:0] mq_word,
    input logic        out_carry
);
    a_r9_done_after_valid: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_done);

    a_r9_no_done_when_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_done);

    a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(dst_word) && $stable(mq_word) && $stable(out_carry)));

    a_r4_full_sign_fill: assert property (@(posedge clk) disable iff (rst)
        (in_valid && shift_opnd[5]) |=> (dst_word == {32{$past(src_word[31])}}));

    a_r8_full_no_carry: assert property (@(posedge clk) disable iff (rst)
        (in_valid && shift_opnd[5]) |=> !out_carry);

    a_r7_positive_no_carry: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !src_word[31]) |=> !out_carry);

    a_r2_zero_count_mq: assert property (@(posedge clk) disable iff (rst)
        (in_valid && shift_opnd[4:0] == 5'd0) |=> (mq_word == $past(src_word)));

    a_r10_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_done && dst_word == '0 && mq_word == '0 && !out_carry));
endmodule

bind sra_mq_unit sra_mq_checker u_chk (.*);

// File: tb/sim_sra_mq_unit.sv
module sim_sra_mq_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] src_word = '0;
    logic [31:0] shift_opnd = '0;
    logic        out_done;
    logic [31:0] dst_word;
    logic [31:0] mq_word;
    logic        out_carry;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sra_mq_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .src_word(src_word), .shift_opnd(shift_opnd),
        .out_done(out_done), .dst_word(dst_word),
        .mq_word(mq_word), .out_carry(out_carry)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%08h expected=%08h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_rotr(input logic [31:0] v, input int n);
        if (n == 0) return v;
        return (v >> n) | (v << (32 - n));
    endfunction

    // Issue one operation, then check all outputs one cycle later.
    task automatic run_op(input string req, input logic [31:0] s, input logic [31:0] b);
        int n;
        logic [31:0] e_dst, e_mq;
        logic e_c;
        n = int'(b[4:0]);
        e_mq = ref_rotr(s, n);
        if (b[5]) begin
            e_dst = {32{s[31]}};
            e_c = 1'b0;
        end else begin
            e_dst = 32'($signed(s) >>> n);
            e_c = s[31] && ((s & ((32'd1 << n) - 32'd1)) != 0);
        end
        @(negedge clk);
        src_word = s; shift_opnd = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(req, "done", {31'd0, out_done}, 32'd1);
        chk(req, "dst", dst_word, e_dst);
        chk(req, "mq", mq_word, e_mq);
        chk(req, "carry", {31'd0, out_carry}, {31'd0, e_c});
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R10", "done", {31'd0, out_done}, 32'd0);
        chk("R10", "dst", dst_word, 32'd0);
        chk("R10", "mq", mq_word, 32'd0);
        chk("R10", "carry", {31'd0, out_carry}, 32'd0);
    endtask

    task automatic t_partial_shift;
        run_op("R3", 32'h8000_0000, 32'd1);
        run_op("R3", 32'hF0F0_1234, 32'd4);
        run_op("R3", 32'h7654_3210, 32'd8);
        run_op("R3", 32'hFFFF_FFFF, 32'd31);
        run_op("R2", 32'h1234_5678, 32'd0);
        run_op("R2", 32'hDEAD_BEEF, 32'd13);
    endtask

    task automatic t_carry;
        run_op("R6", 32'h8000_0001, 32'd1);
        run_op("R6", 32'h8000_0010, 32'd4);
        run_op("R6", 32'h8000_0010, 32'd5);
        run_op("R7", 32'h7FFF_FFFF, 32'd16);
        run_op("R7", 32'h0000_00FF, 32'd31);
    endtask

    task automatic t_full_fill;
        run_op("R4", 32'h8000_00FF, 32'd32);
        run_op("R4", 32'h7FFF_FFFF, 32'd39);
        run_op("R8", 32'hFFFF_FFFF, 32'd63);
    endtask

    task automatic t_select_bit;
        run_op("R5", 32'hC000_0003, 32'd64);
        run_op("R1", 32'h9ABC_DEF1, 32'hFFFF_FFC3);
        run_op("R1", 32'h8765_4321, 32'h1234_5607);
    endtask

    task automatic t_pulse_hold;
        logic [31:0] d0, m0;
        run_op("R9", 32'hA5A5_A5A5, 32'd3);
        d0 = dst_word; m0 = mq_word;
        src_word = 32'h0000_0001; shift_opnd = 32'd40;
        @(negedge clk);
        chk("R9", "done low", {31'd0, out_done}, 32'd0);
        chk("R9", "dst hold", dst_word, d0);
        chk("R9", "mq hold", mq_word, m0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst = 1'b0;
        t_partial_shift;
        t_carry;
        t_full_fill;
        t_select_bit;
        t_pulse_hold;
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule